// File: doc/BRIEF.md
# Parity-Checked Cell Ingress

This block takes fixed-length cells from a layer processor over a transmit bus that is 8 or 16 bits wide. Each transfer carries its own odd-parity bit, and the block checks that bit on every transfer. The processor marks the first transfer of each cell with a start flag. The block counts transfers from that flag to find the end of the cell. The cell length follows the bus width and a short-cell option: 53 or 52 transfers on the narrow bus, and 27 or 26 on the wide bus. On the wide bus the 27-transfer form carries a stuff byte.

Each cell is assembled in one half of a two-cell buffer. When the last transfer arrives, the block decides what to do with the cell. It can hand the cell to a downstream cell FIFO, drop it because it contained a parity error and discard is on, or drop it because the FIFO reports no room. A handed-over cell is streamed to the FIFO write port one word per cycle while the other half of the buffer fills.

Three sticky status flags record parity errors, overruns and framing slips. Each flag clears when the status register is read. Each flag drives the interrupt output through its own enable.

Top module: `txCellIngress`

## Requirements
- R1: A transfer has a parity error when the count of ones in the checked lane plus `inParity` is even. The checked lane is `inData[7:0]` when the wide bit is 0 and `inData[15:0]` when it is 1. A parity error sets status bit 0.
- R2: The cell length in transfers is set by the config register at address 0. Bit 0 selects the wide bus and bit 1 selects short cells. The lengths are 53 (narrow, long), 27 (wide, long), 52 (narrow, short) and 26 (wide, short).
- R3: The control register at address 1 has bit 0 as discard. When discard is 1, a cell with any parity error writes nothing to the FIFO. When discard is 0, the cell is written in full.
- R4: A kept cell is written on consecutive cycles, starting the cycle after its last transfer. Words go out in arrival order, and `fifoWrSoc` is high on the first word only. In narrow mode bits 15:8 of each word are zero. Back-to-back cells are all delivered.
- R5: A start flag that arrives before the current cell is complete sets status bit 2. The partial cell is dropped and a new cell begins with that transfer.
- R6: A transfer without a start flag while no cell is open sets status bit 2 and is otherwise ignored.
- R7: If `fifoFull` is high on the last transfer of a cell that would be kept, the cell is dropped and status bit 1 is set.
- R8: Reading address 2 clears all status bits. A status event in the same cycle as that read leaves its bit set.
- R9: `irq` is high exactly when some status bit is set together with its enable. The enables are control bits 1, 2 and 3 for status bits 0, 1 and 2.
- R10: After reset all registers read 0, `irq` is low and `fifoWrEn` is low.
- R11: `regRdData` shows the register selected by `regAddr` in the cycle after `regRdEn`. Unused bits and address 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 16 | Transfer data |
| inParity | input | 1 | Odd parity of the transfer |
| inValid | input | 1 | Transfer qualifier |
| inSoc | input | 1 | First transfer of a cell |
| fifoFull | input | 1 | FIFO cannot take a whole cell |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrSoc | output | 1 | First word of a cell |
| fifoWrData | output | 16 | FIFO write word |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 4 | Register write data |
| regRdData | output | 4 | Register read data |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume that the bus width and short-cell bits do not change while a cell is open. They also assume that `fifoFull` describes room for a whole cell, because it is only sampled on a cell's last transfer. The stimulus writes the configuration only between cells, after the previous cell has drained, and changes `fifoFull` only while the bus is idle. The assertion that a status read clears every flag holds only when no transfer arrives in the same cycle. The bench therefore tests the simultaneous case separately, and it is checked against the reference model rather than by that property.

// File: rtl/cellIngressPkg.sv
`timescale 1ns/1ps
package cellIngressPkg;
  parameter int LONG_BYTES  = 53;
  parameter int SHORT_BYTES = 52;
  parameter int BUS_W       = 16;
  parameter int LANE_W      = 8;
  parameter int REG_W       = 4;
  localparam int DEPTH  = LONG_BYTES;
  localparam int IDX_W  = $clog2(DEPTH + 1);
  localparam int STAT_W = 3;
  localparam int ST_PAR = 0;
  localparam int ST_OVR = 1;
  localparam int ST_ALN = 2;

  typedef enum logic [1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_CTL  = 2'd1,
    ADDR_STAT = 2'd2
  } regAddr_e;

  typedef struct packed {
    logic             bufWr;
    logic             fillBank;
    logic [IDX_W-1:0] fillIdx;
    logic             drainBank;
    logic [IDX_W-1:0] drainIdx;
  } pathStrobe_t;
endpackage

// File: rtl/cellIngressPath.sv
`timescale 1ns/1ps
module cellIngressPath
  import cellIngressPkg::*;
(
  input  logic             clk,
  input  logic [BUS_W-1:0] inData,
  input  logic             inParity,
  input  logic             wideMode,
  input  pathStrobe_t      strobe,
  output logic             parOk,
  output logic [BUS_W-1:0] wrData
);
  localparam int BANKS = 2;

  logic [BUS_W-1:0] laneData;
  logic [BUS_W-1:0] bufMem [BANKS][DEPTH];

  // narrow mode checks and stores only the low lane
  assign laneData = wideMode ? inData : {{(BUS_W-LANE_W){1'b0}}, inData[LANE_W-1:0]};
  // odd parity: data ones plus parity bit must be odd
  assign parOk = (^laneData) ^ inParity;

  for (genvar b = 0; b < BANKS; b++) begin : gBank
    always_ff @(posedge clk) begin
      if (strobe.bufWr && (strobe.fillBank == 1'(b)))
        bufMem[b][strobe.fillIdx] <= laneData;
    end
  end

  assign wrData = bufMem[strobe.drainBank][strobe.drainIdx];
endmodule

// File: rtl/cellIngressCtrl.sv
`timescale 1ns/1ps
module cellIngressCtrl
  import cellIngressPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSoc,
  input  logic              parOk,
  input  logic              fifoFull,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              wideMode,
  output pathStrobe_t       strobe,
  output logic              fifoWrEn,
  output logic              fifoWrSoc,
  output logic [STAT_W-1:0] statBits,
  output logic [STAT_W-1:0] enBits
);
  localparam logic [IDX_W-1:0] LEN_N_L = IDX_W'(LONG_BYTES);
  localparam logic [IDX_W-1:0] LEN_W_L = IDX_W'((LONG_BYTES + 1) / 2);
  localparam logic [IDX_W-1:0] LEN_N_S = IDX_W'(SHORT_BYTES);
  localparam logic [IDX_W-1:0] LEN_W_S = IDX_W'((SHORT_BYTES + 1) / 2);

  logic [1:0]        cfgReg;
  logic [REG_W-1:0]  ctlReg;
  logic [STAT_W-1:0] statReg, statSet, statClr;
  logic [IDX_W-1:0]  fillCnt, nextCnt, cellLen, drainCnt, drainLen;
  logic errFlag, fillBank, drainBank, drainBusy;
  logic inCell, startCell, accept, lastXfer, cellErr, keepCell, commit, overrun, alignErr;

  assign wideMode = cfgReg[0];

  always_comb begin
    case (cfgReg)
      2'b00:   cellLen = LEN_N_L;
      2'b01:   cellLen = LEN_W_L;
      2'b10:   cellLen = LEN_N_S;
      default: cellLen = LEN_W_S;
    endcase
  end

  // framing decisions for the current transfer
  assign inCell    = (fillCnt != '0);
  assign startCell = inValid && inSoc;
  assign accept    = inValid && (inSoc || inCell);
  assign nextCnt   = startCell ? IDX_W'(1) : fillCnt + IDX_W'(1);
  assign lastXfer  = accept && (nextCnt == cellLen);
  assign cellErr   = (!startCell && errFlag) || !parOk;
  assign keepCell  = lastXfer && !(cellErr && ctlReg[0]);
  assign commit    = keepCell && !fifoFull;
  assign overrun   = keepCell && fifoFull;
  assign alignErr  = inValid && (inSoc == inCell);

  always_comb begin
    statSet         = '0;
    statSet[ST_PAR] = inValid && !parOk;
    statSet[ST_OVR] = overrun;
    statSet[ST_ALN] = alignErr;
    statClr         = (regRdEn && regAddr == ADDR_STAT) ? '1 : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt   <= '0;
      errFlag   <= 1'b0;
      fillBank  <= 1'b0;
      drainBank <= 1'b0;
      drainBusy <= 1'b0;
      drainCnt  <= '0;
      drainLen  <= '0;
      cfgReg    <= '0;
      ctlReg    <= '0;
      statReg   <= '0;
      regRdData <= '0;
    end else begin
      if (lastXfer)    fillCnt <= '0;
      else if (accept) fillCnt <= nextCnt;
      if (accept) errFlag <= cellErr;

      if (commit) begin
        fillBank  <= !fillBank;
        drainBank <= fillBank;
        drainBusy <= 1'b1;
        drainCnt  <= '0;
        drainLen  <= cellLen;
      end else if (drainBusy) begin
        if (drainCnt == drainLen - IDX_W'(1)) drainBusy <= 1'b0;
        else                                   drainCnt  <= drainCnt + IDX_W'(1);
      end

      statReg <= (statReg & ~statClr) | statSet;

      if (regWrEn && regAddr == ADDR_CFG) cfgReg <= regWrData[1:0];
      if (regWrEn && regAddr == ADDR_CTL) ctlReg <= regWrData;

      if (regRdEn) begin
        case (regAddr)
          ADDR_CFG:  regRdData <= {{(REG_W-2){1'b0}}, cfgReg};
          ADDR_CTL:  regRdData <= ctlReg;
          ADDR_STAT: regRdData <= {{(REG_W-STAT_W){1'b0}}, statReg};
          default:   regRdData <= '0;
        endcase
      end
    end
  end

  always_comb begin
    strobe.bufWr     = accept;
    strobe.fillBank  = fillBank;
    strobe.fillIdx   = startCell ? '0 : fillCnt;
    strobe.drainBank = drainBank;
    strobe.drainIdx  = drainCnt;
  end

  assign fifoWrEn  = drainBusy;
  assign fifoWrSoc = drainBusy && (drainCnt == '0);
  assign statBits  = statReg;
  assign enBits    = ctlReg[STAT_W:1];
endmodule

// File: rtl/txCellIngress.sv
`timescale 1ns/1ps
module txCellIngress
  import cellIngressPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  inData,
  input  logic              inParity,
  input  logic              inValid,
  input  logic              inSoc,
  input  logic              fifoFull,
  output logic              fifoWrEn,
  output logic              fifoWrSoc,
  output logic [BUS_W-1:0]  fifoWrData,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              irq
);
  pathStrobe_t       strobe;
  logic              parOk;
  logic              wideMode;
  logic [STAT_W-1:0] statBits, enBits;

  cellIngressCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSoc(inSoc), .parOk(parOk),
    .fifoFull(fifoFull), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .wideMode(wideMode),
    .strobe(strobe), .fifoWrEn(fifoWrEn), .fifoWrSoc(fifoWrSoc),
    .statBits(statBits), .enBits(enBits)
  );

  cellIngressPath uPath (
    .clk(clk), .inData(inData), .inParity(inParity), .wideMode(wideMode),
    .strobe(strobe), .parOk(parOk), .wrData(fifoWrData)
  );

  assign irq = |(statBits & enBits);
endmodule

// File: rtl/txCellIngressChk.sv
`timescale 1ns/1ps
module txCellIngressChk
  import cellIngressPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              regRdEn,
  input logic [1:0]        regAddr,
  input logic              fifoWrEn,
  input logic              fifoWrSoc,
  input logic              irq,
  input logic              parOk,
  input logic [STAT_W-1:0] statBits,
  input logic              bufWr,
  input logic              fillBank,
  input logic              drainBank,
  input logic [IDX_W-1:0]  fillIdx
);
  AST_SOC_LEADS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoWrEn) |-> fifoWrSoc);                                      // R4
  AST_SOC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWrEn && fifoWrSoc) |=> !fifoWrSoc);                             // R4
  AST_BANK_APART: assert property (@(posedge clk) disable iff (!rstN)
    (bufWr && fifoWrEn) |-> (fillBank != drainBank));                    // R4
  AST_PARITY_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !parOk) |=> statBits[ST_PAR]);                           // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_STAT && !inValid) |=> (statBits == '0)); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statBits != '0));                                           // R9
  AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bufWr |-> (fillIdx < IDX_W'(DEPTH)));                                // R2
endmodule

bind txCellIngress txCellIngressChk uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .regRdEn(regRdEn), .regAddr(regAddr),
  .fifoWrEn(fifoWrEn), .fifoWrSoc(fifoWrSoc), .irq(irq), .parOk(parOk),
  .statBits(statBits), .bufWr(strobe.bufWr), .fillBank(strobe.fillBank),
  .drainBank(strobe.drainBank), .fillIdx(strobe.fillIdx)
);

// File: tb/sim_txCellIngress.sv
`timescale 1ns/1ps
module sim_txCellIngress;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, inParity = 1'b0, inValid = 1'b0, inSoc = 1'b0, fifoFull = 1'b0;
  logic [15:0] inData = '0;
  logic fifoWrEn, fifoWrSoc, irq;
  logic [15:0] fifoWrData;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [3:0] regWrData = '0, regRdData;

  txCellIngress u0 (.*);

  int checks = 0, errors = 0, wordsSeen = 0;
  bit wideNow = 1'b0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mCnt = 0;
  bit mErr = 1'b0;
  logic [15:0] mCell[$];
  logic [16:0] expQ[$];
  logic [1:0] mCfg = '0;
  logic [3:0] mCtl = '0, mRd = '0;
  logic [2:0] mStat = '0;
  bit rdValid = 1'b0;

  function automatic int lenOf(logic [1:0] c);
    case (c)
      2'b00: return 53;
      2'b01: return 27;
      2'b10: return 52;
      default: return 26;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [2:0] setS;
    logic [15:0] d;
    bit pe;
    int len;
    if (!rstN) begin
      mCnt = 0; mErr = 0; mCell.delete(); expQ.delete();
      mCfg = '0; mCtl = '0; mStat = '0; rdValid = 0;
    end else begin
      setS = '0;
      len = lenOf(mCfg);
      if (inValid) begin
        d  = mCfg[0] ? inData : {8'h00, inData[7:0]};
        pe = mCfg[0] ? ((^inData) == inParity) : ((^inData[7:0]) == inParity);
        if (pe) setS[0] = 1'b1;
        if (inSoc) begin
          if (mCnt != 0) setS[2] = 1'b1;
          mCnt = 1; mErr = pe; mCell.delete(); mCell.push_back(d);
        end else if (mCnt == 0) begin
          setS[2] = 1'b1;
        end else begin
          mCnt++; mErr = mErr | pe; mCell.push_back(d);
        end
        if (mCnt == len) begin
          if (!(mErr && mCtl[0])) begin
            if (fifoFull) setS[1] = 1'b1;
            else foreach (mCell[i]) expQ.push_back({i == 0, mCell[i]});
          end
          mCnt = 0;
        end
      end
      if (regRdEn) begin
        case (regAddr)
          2'd0: mRd = {2'b00, mCfg};
          2'd1: mRd = mCtl;
          2'd2: mRd = {1'b0, mStat};
          default: mRd = '0;
        endcase
        rdValid = 1'b1;
      end
      mStat = (mStat & ((regRdEn && regAddr == 2'd2) ? 3'b000 : 3'b111)) | setS;
      if (regWrEn && regAddr == 2'd0) mCfg = regWrData[1:0];
      if (regWrEn && regAddr == 2'd1) mCtl = regWrData;
    end
  end

  // compare every cycle, after the outputs settle
  always @(posedge clk) begin : compare
    logic [16:0] e;
    #1;
    if (rstN) begin
      check(fifoWrEn == (expQ.size() > 0), "R4", "write strobe", fifoWrEn, expQ.size() > 0);
      if (fifoWrEn && expQ.size() > 0) begin
        e = expQ.pop_front();
        check({fifoWrSoc, fifoWrData} == e, "R4", "word/soc", {fifoWrSoc, fifoWrData}, e);
        wordsSeen++;
      end
      check(irq == |(mStat & mCtl[3:1]), "R9", "irq", irq, |(mStat & mCtl[3:1]));
      if (rdValid) begin
        check(regRdData == mRd, "R11", "read data", regRdData, mRd);
        rdValid = 1'b0;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic parOf(logic [15:0] d);
    return wideNow ? ~^d : ~^d[7:0];
  endfunction

  task automatic xfer(bit soc, logic [15:0] d, bit bad);
    @(negedge clk);
    inValid = 1'b1; inSoc = soc; inData = d; inParity = parOf(d) ^ bad;
  endtask

  task automatic quiet(int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0; inSoc = 1'b0;
    end
  endtask

  task automatic cellBody(int n, int badAt);
    for (int i = 0; i < n; i++) xfer(i == 0, 16'($urandom), i == badAt);
  endtask

  task automatic regWrite(logic [1:0] a, logic [3:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = v;
    if (a == 2'd0) wideNow = v[0];
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [3:0] v);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    v = regRdData;
  endtask

  task automatic cellWords(int n, int badAt, int expWords, string req);
    int w0;
    w0 = wordsSeen;
    cellBody(n, badAt);
    quiet(60);
    check(wordsSeen - w0 == expWords, req, "words written", wordsSeen - w0, expWords);
  endtask

  task automatic expectStat(logic [3:0] exp, string req);
    logic [3:0] v;
    regRead(2'd2, v);
    check(v == exp, req, "status", v, exp);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual hung, expected completion");
    finishRun();
  end

  initial begin : main
    logic [3:0] v;
    int w0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(fifoWrEn == 1'b0, "R10", "fifoWrEn after reset", fifoWrEn, 0);
    check(irq == 1'b0, "R10", "irq after reset", irq, 0);
    regRead(2'd0, v); check(v == 4'h0, "R10", "cfg reset", v, 0);
    regRead(2'd1, v); check(v == 4'h0, "R10", "ctl reset", v, 0);
    expectStat(4'h0, "R10");
    regRead(2'd3, v); check(v == 4'h0, "R11", "unused address", v, 0);

    // R2 R4 narrow long, clean
    cellWords(53, -1, 53, "R2");
    // R3 R1 discard off with interrupts enabled, errored cell kept
    regWrite(2'd1, 4'b1110);
    cellWords(53, 5, 53, "R3");
    check(irq == 1'b1, "R9", "irq on parity flag", irq, 1);
    expectStat(4'b0001, "R1");
    check(irq == 1'b0, "R8", "irq after clear", irq, 0);
    // R3 discard on: errored cell dropped, last-transfer error too
    regWrite(2'd1, 4'b1111);
    cellWords(53, 12, 0, "R3");
    cellWords(53, 52, 0, "R3");
    expectStat(4'b0001, "R1");
    // R2 wide long, clean then upper-byte-only parity fault
    regWrite(2'd0, 4'b0001);
    cellWords(27, -1, 27, "R2");
    w0 = wordsSeen;
    for (int i = 0; i < 27; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSoc = (i == 0); inData = 16'h0100 | 16'(i);
      inParity = (i == 3) ? ~^inData[7:0] : ~^inData;
    end
    quiet(60);
    check(wordsSeen - w0 == 0, "R1", "upper lane parity drops cell", wordsSeen - w0, 0);
    expectStat(4'b0001, "R1");
    // R2 short modes
    regWrite(2'd0, 4'b0011);
    cellWords(26, -1, 26, "R2");
    regWrite(2'd0, 4'b0010);
    cellWords(52, -1, 52, "R2");
    regWrite(2'd0, 4'b0000);
    // R5 early start flag
    cellBody(10, -1);
    cellWords(53, -1, 53, "R5");
    expectStat(4'b0100, "R5");
    // R6 stray transfer
    xfer(1'b0, 16'h00A5, 1'b0);
    quiet(3);
    expectStat(4'b0100, "R6");
    // R7 fifo full at commit
    fifoFull = 1'b1;
    cellWords(53, -1, 0, "R7");
    fifoFull = 1'b0;
    expectStat(4'b0010, "R7");
    // R8 event in the same cycle as the clearing read
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 2'd2;
    inValid = 1'b1; inSoc = 1'b0; inData = 16'h0033; inParity = parOf(16'h0033);
    @(negedge clk);
    regRdEn = 1'b0; inValid = 1'b0;
    v = regRdData;
    check(v == 4'h0, "R8", "read before set", v, 0);
    expectStat(4'b0100, "R8");
    // R4 back-to-back wide cells, no gap
    regWrite(2'd0, 4'b0001);
    w0 = wordsSeen;
    cellBody(27, -1);
    cellBody(27, -1);
    quiet(60);
    check(wordsSeen - w0 == 54, "R4", "back-to-back words", wordsSeen - w0, 54);
    check(expQ.size() == 0, "R4", "nothing left pending", expQ.size(), 0);
    finishRun();
  end
endmodule